// File: doc/BRIEF.md
# NRZI Decoder with Bit Destuffing

This block sits behind a line-state sampler that delivers one symbol per bit time on a differential serial bus. Each symbol is one of four line states: J, K, single-ended zero (SE0) or single-ended one (SE1). The block recovers the data bits by NRZI decoding. A symbol that matches the last data symbol gives a 1, and a symbol that differs gives a 0. The block then removes the zeros that the transmitter inserted to break up long runs of ones.

Each kept data bit appears on `bit_valid`/`bit_data`. Each dropped stuff bit raises `stuff_drop` for one cycle. A start-of-packet pulse from the sampler resets the decoding state. The block also recognises end of packet by itself: an SE0 followed by a J. The line states and the end-of-packet sequence never produce data bits. Reporting of stuffing violations, byte assembly and packet checks belong to later stages.

Top module: `nrzi_destuff_dec`

## Requirements
- R1: Symbol encoding on `sym_code` is J=2'b00, K=2'b01, SE0=2'b10, SE1=2'b11. A J or K data symbol equal to the previous data symbol decodes to 1, and a J or K that differs from it decodes to 0.
- R2: The previous-symbol state is J after reset. It is also J for a symbol presented together with `pkt_start`.
- R3: Outputs are registered. `bit_valid`, `bit_data` and `stuff_drop` reflect the symbol accepted one cycle earlier. A cycle with `sym_valid` low produces no output pulse.
- R4: A decoded 0 that follows exactly six consecutive kept ones is dropped. For that symbol `bit_valid` stays low and `stuff_drop` is high for one cycle.
- R5: After a dropped stuff bit the ones run restarts from zero. The stuffed symbol becomes the previous symbol for the next decode.
- R6: An SE1 outside end of packet produces no bit. It changes neither the previous symbol nor the ones run.
- R7: An SE0 enters end of packet. From then on no data bit and no stuff drop is produced until a J directly follows an SE0. A K or an SE1 in between is ignored.
- R8: A J directly after an SE0 completes end of packet. It produces no bit, resets the previous symbol to J and clears the ones run.
- R9: `pkt_start` clears the ones run and any end-of-packet state. The symbol presented with it is decoded from that cleared state.
- R10: A 1 decoded while the run already holds six is passed through as data, and the run holds at seven. A following 0 is kept as data.
- R11: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Start-of-packet pulse; clears decoding state |
| sym_valid | input | 1 | A sampled symbol is present on `sym_code` |
| sym_code | input | 2 | Line state: J, K, SE0 or SE1 |
| bit_valid | output | 1 | A recovered data bit is on `bit_data` |
| bit_data | output | 1 | Recovered data bit |
| stuff_drop | output | 1 | One-cycle pulse for each discarded stuff bit |

## Verification
The main function is tried with several symbol patterns, and each one separates a different possible fault:
- Alternating J/K runs and repeated symbols confirm the direction of the NRZI mapping.
- A run of six ones followed by a transition hits the stuff boundary exactly. The symbol after the drop shows whether the previous-symbol state moved with the stuffed symbol.
- Seven ones in a row show that the run saturates instead of dropping a bit.
- Five ones, then end of packet, then more symbols without a start pulse show whether end of packet really cleared the run and the previous symbol.
- SE1, idle gaps, and K symbols inside end of packet show that line states outside the data alphabet leave no trace.

// File: rtl/nrzi_dec_pkg.sv
package nrzi_dec_pkg;

  typedef enum logic [1:0] {
    LS_J   = 2'b00,
    LS_K   = 2'b01,
    LS_SE0 = 2'b10,
    LS_SE1 = 2'b11
  } line_sym_e;

  // NRZI: no transition means 1, a transition means 0
  function automatic logic nrzi_bit(input line_sym_e cur, input line_sym_e prv);
    return (cur == prv);
  endfunction

  function automatic logic is_data_sym(input line_sym_e s);
    return (s == LS_J) || (s == LS_K);
  endfunction

endpackage

// File: rtl/nrzi_line_track.sv
module nrzi_line_track
  import nrzi_dec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pkt_start,
  input  logic      sym_valid,
  input  line_sym_e sym_code,
  output line_sym_e prev_eff,
  output logic      data_sym,
  output logic      eop_done,
  output logic      in_eop_q
);

  line_sym_e prev_q;
  logic      last_se0_q;
  logic      in_eop_eff;
  logic      last_se0_eff;

  always_comb begin
    prev_eff     = pkt_start ? LS_J : prev_q;
    in_eop_eff   = in_eop_q & ~pkt_start;
    last_se0_eff = last_se0_q & ~pkt_start;
    data_sym     = sym_valid && is_data_sym(sym_code) && !in_eop_eff;
    eop_done     = sym_valid && (sym_code == LS_J) && last_se0_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q     <= LS_J;
      in_eop_q   <= 1'b0;
      last_se0_q <= 1'b0;
    end else begin
      if (eop_done)      prev_q <= LS_J;
      else if (data_sym) prev_q <= sym_code;
      else               prev_q <= prev_eff;

      if (sym_valid && sym_code == LS_SE0) in_eop_q <= 1'b1;
      else if (eop_done)                   in_eop_q <= 1'b0;
      else                                 in_eop_q <= in_eop_eff;

      last_se0_q <= sym_valid ? (sym_code == LS_SE0) : last_se0_eff;
    end
  end

endmodule

// File: rtl/nrzi_run_count.sv
module nrzi_run_count #(
  parameter int STUFF_RUN = 6,
  parameter int CW        = $clog2(STUFF_RUN + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_now,
  input  logic          clr_after,
  input  logic          data_sym,
  input  logic          one_bit,
  output logic          is_stuff,
  output logic [CW-1:0] run_q
);

  localparam logic [CW-1:0] RUN_LIM = CW'(STUFF_RUN);
  localparam logic [CW-1:0] RUN_SAT = CW'(STUFF_RUN + 1);

  logic [CW-1:0] run_eff;
  logic [CW-1:0] run_nxt;

  always_comb begin
    run_eff  = clr_now ? '0 : run_q;
    is_stuff = data_sym && !one_bit && (run_eff == RUN_LIM);
    if (clr_after)
      run_nxt = '0;
    else if (data_sym)
      run_nxt = one_bit ? ((run_eff == RUN_SAT) ? RUN_SAT : run_eff + 1'b1) : '0;
    else
      run_nxt = run_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_nxt;
  end

endmodule

// File: rtl/nrzi_bit_out.sv
module nrzi_bit_out (
  input  logic clk,
  input  logic rst_n,
  input  logic keep_bit,
  input  logic bit_in,
  input  logic drop_bit,
  output logic bit_valid,
  output logic bit_data,
  output logic stuff_drop
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_valid  <= 1'b0;
      bit_data   <= 1'b0;
      stuff_drop <= 1'b0;
    end else begin
      bit_valid  <= keep_bit;
      bit_data   <= keep_bit & bit_in;
      stuff_drop <= drop_bit;
    end
  end

endmodule

// File: rtl/nrzi_destuff_dec.sv
module nrzi_destuff_dec
  import nrzi_dec_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_start,
  input  logic       sym_valid,
  input  logic [1:0] sym_code,
  output logic       bit_valid,
  output logic       bit_data,
  output logic       stuff_drop
);

  localparam int CW = $clog2(STUFF_RUN + 2);

  line_sym_e     cur_sym;
  line_sym_e     prev_eff;
  logic          data_sym;
  logic          eop_done;
  logic          in_eop_q;
  logic          one_bit;
  logic          is_stuff;
  logic          keep_bit;
  logic [CW-1:0] run_q;

  assign cur_sym  = line_sym_e'(sym_code);
  assign one_bit  = nrzi_bit(cur_sym, prev_eff);
  assign keep_bit = data_sym && !is_stuff;

  nrzi_line_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_start (pkt_start),
    .sym_valid (sym_valid),
    .sym_code  (cur_sym),
    .prev_eff  (prev_eff),
    .data_sym  (data_sym),
    .eop_done  (eop_done),
    .in_eop_q  (in_eop_q)
  );

  nrzi_run_count #(.STUFF_RUN(STUFF_RUN), .CW(CW)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_now   (pkt_start),
    .clr_after (eop_done),
    .data_sym  (data_sym),
    .one_bit   (one_bit),
    .is_stuff  (is_stuff),
    .run_q     (run_q)
  );

  nrzi_bit_out u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .keep_bit   (keep_bit),
    .bit_in     (one_bit),
    .drop_bit   (is_stuff),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .stuff_drop (stuff_drop)
  );

endmodule

// File: rtl/nrzi_destuff_chk.sv
module nrzi_destuff_chk #(
  parameter int STUFF_RUN = 6,
  parameter int CW        = $clog2(STUFF_RUN + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pkt_start,
  input logic          sym_valid,
  input logic          bit_valid,
  input logic          bit_data,
  input logic          stuff_drop,
  input logic          eop_done,
  input logic          in_eop_q,
  input logic [CW-1:0] run_q
);

  // R3
  out_follows_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid || stuff_drop) |-> $past(sym_valid));

  // R4
  drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && stuff_drop));

  // R5
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_drop |-> (run_q == '0));

  // R7
  eop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_eop_q && !pkt_start) |=> (!bit_valid && !stuff_drop));

  // R8
  eop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_done |=> (run_q == '0));

  // R10
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CW'(STUFF_RUN + 1));

  // R1
  one_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_data) |-> (run_q != '0));

endmodule

bind nrzi_destuff_dec nrzi_destuff_chk #(.STUFF_RUN(STUFF_RUN), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pkt_start  (pkt_start),
  .sym_valid  (sym_valid),
  .bit_valid  (bit_valid),
  .bit_data   (bit_data),
  .stuff_drop (stuff_drop),
  .eop_done   (eop_done),
  .in_eop_q   (in_eop_q),
  .run_q      (run_q)
);

// File: tb/test_nrzi_destuff_dec.sv
`timescale 1ns/1ps
module test_nrzi_destuff_dec;

  localparam logic [1:0] SJ = 2'b00, SK = 2'b01, S0 = 2'b10, S1 = 2'b11;
  localparam int NV = 50;

  // {req[3:0], pkt_start, sym_valid, code[1:0], exp_valid, exp_data, exp_drop}
  function automatic logic [10:0] mk(input int r, input logic ps, input logic sv,
                                     input logic [1:0] c, input logic ev,
                                     input logic ed, input logic ex);
    return {4'(r), ps, sv, c, ev, ed, ex};
  endfunction

  localparam logic [10:0] VEC [NV] = '{
    mk(2, 1,1,SK, 1,0,0),  // R2 first K after start decodes 0
    mk(1, 0,1,SK, 1,1,0),  // R1
    mk(1, 0,1,SK, 1,1,0),
    mk(1, 0,1,SJ, 1,0,0),
    mk(4, 0,1,SJ, 1,1,0),  // R4 ones 1..6
    mk(4, 0,1,SJ, 1,1,0),
    mk(4, 0,1,SJ, 1,1,0),
    mk(4, 0,1,SJ, 1,1,0),
    mk(4, 0,1,SJ, 1,1,0),
    mk(4, 0,1,SJ, 1,1,0),
    mk(4, 0,1,SK, 0,0,1),  // R4 stuff dropped
    mk(5, 0,1,SK, 1,1,0),  // R5 prev followed stuffed K
    mk(3, 0,0,SJ, 0,0,0),  // R3 idle cycle
    mk(5, 0,1,SK, 1,1,0),
    mk(6, 0,1,S1, 0,0,0),  // R6 SE1 ignored
    mk(6, 0,1,SK, 1,1,0),
    mk(7, 0,1,S0, 0,0,0),  // R7
    mk(7, 0,1,S0, 0,0,0),
    mk(8, 0,1,SJ, 0,0,0),  // R8 end of packet
    mk(2, 1,1,SK, 1,0,0),  // R2
    mk(10,0,1,SK, 1,1,0),  // R10 ones 1..6
    mk(10,0,1,SK, 1,1,0),
    mk(10,0,1,SK, 1,1,0),
    mk(10,0,1,SK, 1,1,0),
    mk(10,0,1,SK, 1,1,0),
    mk(10,0,1,SK, 1,1,0),
    mk(10,0,1,SK, 1,1,0),  // seventh one passes
    mk(10,0,1,SJ, 1,0,0),  // zero after saturation kept
    mk(1, 0,1,SJ, 1,1,0),
    mk(7, 0,1,S0, 0,0,0),
    mk(7, 0,1,SK, 0,0,0),  // K inside end of packet ignored
    mk(7, 0,1,S0, 0,0,0),
    mk(8, 0,1,SJ, 0,0,0),
    mk(9, 1,1,SK, 1,0,0),
    mk(9, 0,1,SK, 1,1,0),  // five ones
    mk(9, 0,1,SK, 1,1,0),
    mk(9, 0,1,SK, 1,1,0),
    mk(9, 0,1,SK, 1,1,0),
    mk(9, 0,1,SK, 1,1,0),
    mk(7, 0,1,S0, 0,0,0),
    mk(8, 0,1,SJ, 0,0,0),
    mk(8, 0,1,SJ, 1,1,0),  // R8 prev back at J
    mk(8, 0,1,SK, 1,0,0),  // R8 run was cleared, no stuff
    mk(9, 0,1,SK, 1,1,0),  // R9 six ones
    mk(9, 0,1,SK, 1,1,0),
    mk(9, 0,1,SK, 1,1,0),
    mk(9, 0,1,SK, 1,1,0),
    mk(9, 0,1,SK, 1,1,0),
    mk(9, 0,1,SK, 1,1,0),
    mk(9, 1,1,SK, 1,0,0)   // R9 start clears run: zero kept
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_start = 1'b0;
  logic sym_valid = 1'b0;
  logic [1:0] sym_code = SJ;
  logic bit_valid, bit_data, stuff_drop;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nrzi_destuff_dec i_nrzi_destuff_dec (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .sym_valid(sym_valid),
    .sym_code(sym_code), .bit_valid(bit_valid), .bit_data(bit_data),
    .stuff_drop(stuff_drop)
  );

  task automatic check(input int r, input logic ev, input logic ed, input logic ex);
    total++;
    if ({bit_valid, bit_data, stuff_drop} !== {ev, ed, ex}) begin
      bad++;
      $display("FAIL R%0d step %0d: got v/d/s=%b%b%b expected %b%b%b",
               r, total, bit_valid, bit_data, stuff_drop, ev, ed, ex);
    end
  endtask

  task automatic step(input logic ps, input logic sv, input logic [1:0] c);
    @(negedge clk);
    pkt_start = ps; sym_valid = sv; sym_code = c;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(11, 1'b0, 1'b0, 1'b0);  // R11 reset state
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4:3]);
      check(int'(VEC[i][10:7]), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R11: reset mid-stream clears outputs
    step(1'b0, 1'b1, SJ);
    @(negedge clk);
    rst_n = 1'b0; sym_valid = 1'b0;
    @(posedge clk); #1;
    check(11, 1'b0, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    // R2: previous symbol is J after reset, so K decodes 0
    step(1'b0, 1'b1, SK);
    check(2, 1'b1, 1'b0, 1'b0);
    // R3: no pulse once sym_valid drops
    step(1'b0, 1'b0, SK);
    check(3, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule